// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block turns the system clock into the serial clock of an SPI master. The divide ratio is the product of two factors. A 2-bit prescale code picks a factor from the set 2, 3, 5, 7. A 4-bit scale code picks a factor from a geometric-style table that runs from 2 up to 32768. The serial clock always has a 50% duty cycle, even with an odd prescale factor. This works because every scale factor is even, so half the combined divisor is always a whole number of system cycles.

A neighbouring shift engine holds `runEn` high for as long as it wants clock edges. Along with the clock level, it receives a one-cycle `leadPulse` when the clock leaves its idle level and a one-cycle `trailPulse` when it returns. The engine uses one of these pulses to launch data and the other to sample it, depending on its phase setting. While stopped, the clock rests at the level given by `cpol`. The codes are captured only while the divider is stopped.

Top module: `sckdiv_top`

## Requirements
- R1: Prescale code values 0, 1, 2 and 3 select factors of 2, 3, 5 and 7.
- R2: Scale code values 0 to 3 select factors of 2, 4, 6 and 8. A scale code n from 4 to 15 selects 2 to the power n.
- R3: While running, `sckOut` toggles every H system cycles, where H is the prescale factor times the scale factor divided by two. Both halves of each period are therefore equal.
- R4: While `runEn` is low, `sckOut` equals `cpol` one cycle later, and no edge pulses occur.
- R5: The first toggle of `sckOut` comes H cycles after the cycle in which `runEn` is first sampled high.
- R6: `leadPulse` is high for exactly the one cycle in which `sckOut` has just moved away from the idle level. `trailPulse` does the same for the move back to idle. The two pulses are never high together.
- R7: Changes to the prescale code, the scale code or `cpol` while running have no effect until the divider has been stopped.
- R8: Dropping `runEn` in the middle of a half period returns `sckOut` to idle on the next edge. A later start counts a fresh full H from zero.
- R9: The slowest setting, prescale code 3 with scale code 15, gives H = 114688 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | High to generate serial clock edges |
| preCode | input | 2 | Prescale factor select |
| scaleCode | input | 4 | Scale factor select |
| cpol | input | 1 | Idle level of the serial clock |
| sckOut | output | 1 | Serial clock level |
| leadPulse | output | 1 | One-cycle strobe: clock just left idle |
| trailPulse | output | 1 | One-cycle strobe: clock just returned to idle |

## Verification
The odd prescale factors 3, 5 and 7 are the main concern. A design that divided the half period before multiplying, or that rounded it, would produce unequal halves, and the bench would see one of the two measured half periods come out off by a cycle. The first toggle after a start is timed exactly, which catches counters that are not cleared or that start with an extra cycle. The bench also changes the codes in mid-run and stops the clock in the middle of a half period. These checks expose a design that picks up new codes while running, or that leaves the clock at its active level after a stop. The largest divisor is timed once, to catch a counter that is too narrow or a scale table that is wrong.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  parameter int PRE_W = 2;
  parameter int SCL_W = 4;
  // widest half period: 7 * 2^(2^SCL_W - 1) / 2
  localparam int CNT_W = (1 << SCL_W) + 2;

  typedef struct packed {
    logic toggle;     // flip the clock this edge
    logic clear;      // force idle level this edge
    logic idleLevel;  // level the clock rests at
  } sckStrobe_t;

  function automatic logic [CNT_W-1:0] preFactor(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    return CNT_W'(2);
      2'd1:    return CNT_W'(3);
      2'd2:    return CNT_W'(5);
      default: return CNT_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] scaleFactor(input logic [SCL_W-1:0] code);
    if (code < SCL_W'(4)) return CNT_W'(({28'd0, code} + 32'd1) * 32'd2);
    return CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/sckdiv_ctrl.sv
module sckdiv_ctrl
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [PRE_W-1:0] preCode,
  input  logic [SCL_W-1:0] scaleCode,
  input  logic             cpol,
  output sckStrobe_t       strobe
);
  logic             active;
  logic [PRE_W-1:0] preLat;
  logic [SCL_W-1:0] scaleLat;
  logic             cpolLat;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfCount;
  logic [2*CNT_W-1:0] product;
  logic             atEnd;

  always_comb begin
    product   = preFactor(preLat) * scaleFactor(scaleLat);
    halfCount = product[CNT_W:1];
    atEnd     = (cnt == halfCount - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      preLat   <= '0;
      scaleLat <= '0;
      cpolLat  <= 1'b0;
      cnt      <= '0;
    end else begin
      if (!active) begin
        preLat   <= preCode;
        scaleLat <= scaleCode;
        cpolLat  <= cpol;
      end
      if (!runEn) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (!active) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (atEnd) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.toggle    = active && runEn && atEnd;
    strobe.clear     = !runEn;
    strobe.idleLevel = active ? cpolLat : cpol;
  end

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(halfCount));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt < halfCount));
  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> (cnt == '0));
endmodule

// File: rtl/sckdiv_datapath.sv
module sckdiv_datapath
  import sckdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sckStrobe_t strobe,
  output logic       sckOut,
  output logic       leadPulse,
  output logic       trailPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckOut     <= 1'b0;
      leadPulse  <= 1'b0;
      trailPulse <= 1'b0;
    end else begin
      leadPulse  <= 1'b0;
      trailPulse <= 1'b0;
      if (strobe.clear) begin
        sckOut <= strobe.idleLevel;
      end else if (strobe.toggle) begin
        sckOut     <= ~sckOut;
        leadPulse  <= (sckOut == strobe.idleLevel);
        trailPulse <= (sckOut != strobe.idleLevel);
      end
    end
  end

  assert_pulse_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({leadPulse, trailPulse}));
  assert_pulse_moves_R6: assert property (@(posedge clk) disable iff (!rstN)
    (leadPulse || trailPulse) |-> (sckOut != $past(sckOut)));
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clear) |-> (sckOut == $past(strobe.idleLevel) && !leadPulse && !trailPulse));
endmodule

// File: rtl/sckdiv_top.sv
module sckdiv_top
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [PRE_W-1:0] preCode,
  input  logic [SCL_W-1:0] scaleCode,
  input  logic             cpol,
  output logic             sckOut,
  output logic             leadPulse,
  output logic             trailPulse
);
  sckStrobe_t strobe;

  sckdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .preCode(preCode),
    .scaleCode(scaleCode), .cpol(cpol), .strobe(strobe)
  );

  sckdiv_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sckOut(sckOut), .leadPulse(leadPulse), .trailPulse(trailPulse)
  );
endmodule

// File: tb/sckdiv_top_tb.sv
module sckdiv_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [1:0] preCode = '0;
  logic [3:0] scaleCode = '0;
  logic cpol = 1'b0;
  logic sckOut, leadPulse, trailPulse;
  int runCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit timedOut = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cycles++;

  sckdiv_top u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .preCode(preCode),
    .scaleCode(scaleCode), .cpol(cpol), .sckOut(sckOut),
    .leadPulse(leadPulse), .trailPulse(trailPulse)
  );

  // {pre, scale, cpol, expected half period}
  localparam int NVEC = 8;
  localparam logic [6:0]  VPRE [NVEC] = '{0, 1, 2, 3, 1, 2, 3, 0};
  localparam logic [3:0]  VSCL [NVEC] = '{0, 0, 1, 1, 3, 4, 5, 7};
  localparam logic        VPOL [NVEC] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int          VHALF[NVEC] = '{2, 3, 10, 14, 12, 40, 112, 128};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count posedges until sckOut changes; sampled at negedge
  task automatic measure(output int n);
    logic prev = sckOut;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sckOut != prev) break;
      if (cycles > 199000) begin timedOut = 1'b1; break; end
    end
  endtask

  task automatic goIdle(input logic [1:0] p, input logic [3:0] s, input logic c);
    @(negedge clk);
    runEn = 1'b0; preCode = p; scaleCode = s; cpol = c;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic start();
    runEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sckOut == 1'b0 && !leadPulse && !trailPulse, "R4 reset", sckOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 prescale, R2 scale, R3 halves, R5 first edge, R6 pulses
    for (int i = 0; i < NVEC; i++) begin
      goIdle(VPRE[i][1:0], VSCL[i], VPOL[i]);
      check(sckOut == VPOL[i], "R4 idle level", sckOut, VPOL[i]);
      start();
      measure(n);
      check(n == VHALF[i], "R5 first half R1 R2", n, VHALF[i]);
      check(leadPulse && !trailPulse, "R6 lead", {leadPulse, trailPulse}, 2);
      measure(n);
      check(n == VHALF[i], "R3 second half", n, VHALF[i]);
      check(trailPulse && !leadPulse && sckOut == VPOL[i], "R6 trail", {leadPulse, trailPulse}, 1);
      @(negedge clk);
      check(!leadPulse && !trailPulse, "R6 single cycle", {leadPulse, trailPulse}, 0);
    end

    // R7: codes changed while running are ignored
    goIdle(2'd0, 4'd0, 1'b0);
    start();
    measure(n);
    preCode = 2'd3; scaleCode = 4'd15; cpol = 1'b1;
    measure(n);
    check(n == 2, "R7 code change ignored", n, 2);
    measure(n);
    check(n == 2, "R7 still old rate", n, 2);

    // R8: stop mid half period, then fresh restart
    goIdle(2'd1, 4'd1, 1'b0);
    start();
    measure(n);
    repeat (3) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    check(sckOut == 1'b0 && !leadPulse && !trailPulse, "R8 stop to idle", sckOut, 0);
    repeat (2) @(negedge clk);
    start();
    measure(n);
    check(n == 6, "R8 fresh restart", n, 6);

    // R9: slowest setting
    goIdle(2'd3, 4'd15, 1'b0);
    start();
    measure(n);
    check(!timedOut && n == 114688, "R9 slowest half", n, 114688);
    check(leadPulse, "R9 lead", leadPulse, 1);

    if (timedOut) check(1'b0, "watchdog", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    wait (cycles > 199500);
    failCount++; runCount++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule